// File: doc/BRIEF.md
# Prioritized Interrupt Collector with Fast-Line Steering

This block collects a parameterized number of interrupt sources, 64 by default, and drives two request lines toward a processor. The first is a normal, vectored IRQ line that comes with the number of the winning source. The second is a fast FIQ line that carries no vector. Each source has a five-bit configuration word. The word holds a two-level-bit priority, an enable, a software-force bit and a bit that steers the source to the fast line, where it skips arbitration.

Software reaches the configuration words over a small memory-mapped bus. Every word has four aliases. One writes the value directly. The others set, clear or toggle the bits written as one, so a single field can change in one atomic access. The processor acknowledges the vector it was given. A matching acknowledge withdraws that source's software-forced request.

Top module: `icoll_top`

## Requirements
- R1: After reset, every configuration word reads 0, `irqOut` and `fiqOut` are 0, and `irqVector` is 0.
- R2: A configuration word packs priority in bits 1:0 (3 strongest, 0 weakest), enable in bit 2, software force in bit 3 and fast-line steer in bit 4. Bits 31:5 read as 0, and writes to them are ignored.
- R3: Source n's word is at byte address 0x120 + 0x10·n. A write at offset +0x0 replaces all five bits. A read at any of the four aliases returns the word.
- R4: A write at offset +0x4 sets each bit that is 1 in the write data and leaves the others unchanged.
- R5: A write at offset +0x8 clears each bit that is 1 in the write data and leaves the others unchanged.
- R6: A write at offset +0xC inverts each bit that is 1 in the write data and leaves the others unchanged.
- R7: A source is requesting when (hardware input OR software force) AND enable holds. A disabled source affects neither output.
- R8: Among requesting sources that are not steered, the highest priority level wins the vector.
- R9: Among winners of equal priority, the lowest source number wins.
- R10: `fiqOut` is the OR of the requesting sources whose steer bit is 1. Such sources never drive `irqOut` or the vector.
- R11: `irqOut`, `irqVector` and `fiqOut` are registered. They reflect the configuration and inputs of the previous cycle. `irqVector` is 0 whenever `irqOut` is 0.
- R12: An acknowledge whose index equals `irqVector` while `irqOut` is 1 clears that source's software-force bit. Any other acknowledge has no effect.
- R13: Bus accesses outside the word array, below 0x120 or at or beyond 0x120 + 0x10·NUM_SRC, change no state and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| hwIrq | input | NUM_SRC | Level-sensitive hardware requests |
| ackValid | input | 1 | Acknowledge strobe |
| ackIdx | input | IDX_W | Acknowledged source number |
| irqOut | output | 1 | Vectored interrupt request |
| irqVector | output | IDX_W | Winning source number |
| fiqOut | output | 1 | Fast, non-vectored request |

## Verification
The bench goes after tie-breaking and priority order. An arbiter with a reversed scan would give equal-priority ties to the highest source number. One with a reversed compare would pick level 0 over level 3. It also checks that steered sources stay out of the vectored path, since leaking them would raise `irqOut` on a fast-line-only request. The alias offsets are exercised with overlapping masks, which catches set, clear and toggle swapped with one another. Finally, it sends mismatched acknowledges and out-of-range writes, which a loose compare or a missing range check would let corrupt a neighbouring source's word.

// File: rtl/icoll_pkg.sv
package icoll_pkg;
  localparam int CFG_W     = 5;
  localparam int PRIO_LSB  = 0;
  localparam int EN_BIT    = 2;
  localparam int SOFT_BIT  = 3;
  localparam int STEER_BIT = 4;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } aliasOp_e;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    aliasOp_e         wrOp;
    logic [CFG_W-1:0] wrBits;
    logic             ackEn;
  } ctrlStrb_t;
endpackage

// File: rtl/icoll_ctrl.sv
module icoll_ctrl
  import icoll_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h120,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              ackValid,
  output ctrlStrb_t         strb,
  output logic [IDX_W-1:0]  regIdx
);
  localparam int SLOT_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] offs;
  logic [SLOT_W-1:0] slot;
  logic              regHit;

  always_comb begin
    offs   = busAddr - BASE_V;
    slot   = offs[ADDR_W-1:4];
    regHit = (busAddr >= BASE_V) && (int'(slot) < NUM_SRC);
    regIdx = slot[IDX_W-1:0];

    strb.wrEn   = busSel && busWr && regHit;
    strb.rdEn   = busSel && !busWr && regHit;
    strb.wrOp   = aliasOp_e'(busAddr[3:2]);
    strb.wrBits = busWdata[CFG_W-1:0];
    strb.ackEn  = ackValid;
  end
endmodule

// File: rtl/icoll_datapath.sv
module icoll_datapath
  import icoll_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [IDX_W-1:0]   regIdx,
  input  logic [IDX_W-1:0]   ackIdx,
  input  logic [NUM_SRC-1:0] hwIrq,
  output logic [31:0]        busRdata,
  output logic               irqOut,
  output logic [IDX_W-1:0]   irqVector,
  output logic               fiqOut
);
  logic [NUM_SRC-1:0][CFG_W-1:0] cfgQ, cfgNxt;
  logic [NUM_SRC-1:0] effReq, irqReqVec, fiqReqVec;
  logic               ackHit;
  logic               found;
  logic [1:0]         bestPrio;
  logic [IDX_W-1:0]   bestIdx;

  assign ackHit = strb.ackEn && irqOut && (ackIdx == irqVector);

  // Register update: alias operation first, then acknowledge clears soft bit.
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      cfgNxt[i] = cfgQ[i];
      if (strb.wrEn && regIdx == IDX_W'(i)) begin
        unique case (strb.wrOp)
          OP_WRITE:  cfgNxt[i] = strb.wrBits;
          OP_SET:    cfgNxt[i] = cfgQ[i] | strb.wrBits;
          OP_CLEAR:  cfgNxt[i] = cfgQ[i] & ~strb.wrBits;
          OP_TOGGLE: cfgNxt[i] = cfgQ[i] ^ strb.wrBits;
          default:   cfgNxt[i] = cfgQ[i];
        endcase
      end
      if (ackHit && irqVector == IDX_W'(i)) cfgNxt[i][SOFT_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgNxt;
  end

  assign busRdata = strb.rdEn ? {{(32-CFG_W){1'b0}}, cfgQ[regIdx]} : 32'd0;

  // Per-source request qualification and routing.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign effReq[g]    = (hwIrq[g] | cfgQ[g][SOFT_BIT]) & cfgQ[g][EN_BIT];
    assign irqReqVec[g] = effReq[g] & ~cfgQ[g][STEER_BIT];
    assign fiqReqVec[g] = effReq[g] &  cfgQ[g][STEER_BIT];
  end

  // Descending scan with >= leaves the lowest index on equal priority.
  always_comb begin
    found    = 1'b0;
    bestPrio = 2'd0;
    bestIdx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (irqReqVec[i] && (!found || cfgQ[i][PRIO_LSB +: 2] >= bestPrio)) begin
        found    = 1'b1;
        bestPrio = cfgQ[i][PRIO_LSB +: 2];
        bestIdx  = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut    <= 1'b0;
      irqVector <= '0;
      fiqOut    <= 1'b0;
    end else begin
      irqOut    <= found;
      irqVector <= found ? bestIdx : '0;
      fiqOut    <= |fiqReqVec;
    end
  end

  // R4
  set_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrOp == OP_SET && !ackHit)
      |=> ((cfgQ[$past(regIdx)] & $past(strb.wrBits)) == $past(strb.wrBits)));

  // R5
  clear_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrOp == OP_CLEAR)
      |=> ((cfgQ[$past(regIdx)] & $past(strb.wrBits)) == '0));

  // R12
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackHit |=> !cfgQ[$past(irqVector)][SOFT_BIT]);

  // R11
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|irqReqVec) |=> !irqOut);

  // R11
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> irqVector == '0);

  // R13
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrEn && !ackHit) |=> $stable(cfgQ));

  // R10
  fiq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fiqOut) |-> $past(|fiqReqVec));
endmodule

// File: rtl/icoll_top.sv
module icoll_top
  import icoll_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h120,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] hwIrq,
  input  logic               ackValid,
  input  logic [IDX_W-1:0]   ackIdx,
  output logic               irqOut,
  output logic [IDX_W-1:0]   irqVector,
  output logic               fiqOut
);
  ctrlStrb_t        strb;
  logic [IDX_W-1:0] regIdx;

  icoll_ctrl #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .ackValid(ackValid), .strb(strb), .regIdx(regIdx)
  );

  icoll_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regIdx(regIdx), .ackIdx(ackIdx),
    .hwIrq(hwIrq), .busRdata(busRdata), .irqOut(irqOut),
    .irqVector(irqVector), .fiqOut(fiqOut)
  );
endmodule

// File: tb/icoll_top_tb.sv
module icoll_top_tb;
  localparam int NSRC  = 8;
  localparam int AW    = 12;
  localparam int IW    = $clog2(NSRC);
  localparam int BASE  = 'h120;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           busSel = 1'b0, busWr = 1'b0;
  logic [AW-1:0]  busAddr = '0;
  logic [31:0]    busWdata = '0;
  logic [31:0]    busRdata;
  logic [NSRC-1:0] hwIrq = '0;
  logic           ackValid = 1'b0;
  logic [IW-1:0]  ackIdx = '0;
  logic           irqOut, fiqOut;
  logic [IW-1:0]  irqVector;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [4:0] sh [NSRC];
  int unsigned lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  icoll_top #(.NUM_SRC(NSRC), .ADDR_W(AW), .BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .hwIrq(hwIrq), .ackValid(ackValid),
    .ackIdx(ackIdx), .irqOut(irqOut), .irqVector(irqVector), .fiqOut(fiqOut)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int addrOf(int s, int op);
    return BASE + 16 * s + 4 * op;
  endfunction

  // Bus write; also updates the bench's shadow of the word when in range.
  task automatic wr(int addr, int data);
    int s;
    logic [4:0] m;
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = AW'(addr); busWdata = data;
    @(negedge clk);
    busSel = 0; busWr = 0;
    m = data[4:0];
    if (addr >= BASE && (addr - BASE) / 16 < NSRC) begin
      s = (addr - BASE) / 16;
      case ((addr >> 2) & 3)
        0: sh[s] = m;
        1: sh[s] = sh[s] | m;
        2: sh[s] = sh[s] & ~m;
        default: sh[s] = sh[s] ^ m;
      endcase
    end
  endtask

  task automatic rd(int addr, output int data);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = AW'(addr);
    #1 data = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  // Reference: ascending scan, strictly greater priority replaces the pick.
  task automatic checkOutputs(string tag);
    int eVec = 0, bestP = -1;
    bit eIrq = 0, eFiq = 0, req;
    for (int i = 0; i < NSRC; i++) begin
      req = (hwIrq[i] | sh[i][3]) & sh[i][2];
      if (req && sh[i][4]) eFiq = 1;
      else if (req && int'(sh[i][1:0]) > bestP) begin
        bestP = int'(sh[i][1:0]); eVec = i; eIrq = 1;
      end
    end
    chk({tag, " irqOut"}, irqOut, eIrq);
    chk({tag, " irqVector"}, irqVector, eVec);
    chk({tag, " fiqOut"}, fiqOut, eFiq);
  endtask

  function automatic int nextRand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return int'(lcg >> 8);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    for (int i = 0; i < NSRC; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irqOut", irqOut, 0);
    chk("R1 fiqOut", fiqOut, 0);
    chk("R1 irqVector", irqVector, 0);
    for (int i = 0; i < NSRC; i++) begin
      rd(addrOf(i, 0), v);
      chk("R1 word", v, 0);
    end

    // R2: reserved bits read zero
    wr(addrOf(2, 0), 32'hFFFF_FFF3);
    rd(addrOf(2, 0), v);
    chk("R2 reserved", v, 32'h13);
    wr(addrOf(2, 0), 0);

    // R3: address map and alias reads
    for (int i = 0; i < NSRC; i++) wr(addrOf(i, 0), (i * 7 + 3) & 32'h13);
    for (int i = 0; i < NSRC; i++)
      for (int op = 0; op < 4; op++) begin
        rd(addrOf(i, op), v);
        chk("R3 map", v, (i * 7 + 3) & 32'h13);
      end

    // R4/R5/R6: alias operations with overlapping masks
    wr(addrOf(3, 0), 5'b00101);
    wr(addrOf(3, 1), 5'b10011);
    rd(addrOf(3, 0), v); chk("R4 set", v, 5'b10111);
    wr(addrOf(3, 2), 5'b00110);
    rd(addrOf(3, 0), v); chk("R5 clear", v, 5'b10001);
    wr(addrOf(3, 3), 5'b11011);
    rd(addrOf(3, 0), v); chk("R6 toggle", v, 5'b01010);

    // R13: out-of-range accesses
    for (int i = 0; i < NSRC; i++) wr(addrOf(i, 0), 0);
    wr(BASE - 16, 5'b11111);
    wr(BASE + 16 * NSRC, 5'b11111);
    wr(BASE + 16 * NSRC + 8, 5'b11111);
    for (int i = 0; i < NSRC; i++) begin
      rd(addrOf(i, 0), v); chk("R13 neighbour", v, 0);
    end
    rd(BASE + 16 * NSRC, v); chk("R13 read", v, 0);
    rd(BASE - 4, v); chk("R13 read low", v, 0);

    // R7: disabled sources ignored
    hwIrq = '1;
    settle();
    checkOutputs("R7 disabled");
    hwIrq = '0;

    // R8/R9: priority order and ties
    wr(addrOf(5, 0), 5'b01111);
    wr(addrOf(1, 0), 5'b01111);
    wr(addrOf(0, 0), 5'b01110);
    settle();
    chk("R9 tie", irqVector, 1);
    checkOutputs("R9");
    wr(addrOf(1, 2), 5'b00001);
    settle();
    chk("R8 level", irqVector, 5);
    checkOutputs("R8");

    // R10: steered source
    wr(addrOf(5, 1), 5'b10000);
    wr(addrOf(1, 0), 0);
    wr(addrOf(0, 0), 0);
    settle();
    chk("R10 fiq", fiqOut, 1);
    chk("R10 no irq", irqOut, 0);
    checkOutputs("R10");

    // R12: acknowledge
    wr(addrOf(5, 0), 0);
    wr(addrOf(6, 0), 5'b01110);
    settle();
    @(negedge clk); ackValid = 1; ackIdx = 3;
    @(negedge clk); ackValid = 0;
    settle();
    rd(addrOf(6, 0), v); chk("R12 mismatch ignored", v, 5'b01110);
    chk("R12 still pending", irqOut, 1);
    @(negedge clk); ackValid = 1; ackIdx = 6;
    @(negedge clk); ackValid = 0;
    sh[6][3] = 0;
    settle();
    rd(addrOf(6, 0), v); chk("R12 cleared", v, 5'b00110);
    chk("R12 irq drops", irqOut, 0);

    // R7/R8/R9/R10/R11: model-based sweep
    for (int it = 0; it < 300; it++) begin
      wr(addrOf(nextRand() % NSRC, nextRand() % 4), nextRand());
      hwIrq = NSRC'(nextRand());
      settle();
      checkOutputs("R11 sweep");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule